// File: doc/BRIEF.md
# Match and Capture Timer-Counter

This block is a 32-bit timer-counter with a word-addressed register port. Its main counter advances either once per programmable number of clock cycles or once per chosen edge of one of its input pins. Four comparison registers watch the counter. When the counter equals one of them on a counting step, that channel can raise an interrupt flag, send the counter back to zero, stop counting, and change the level of its own external output pin.

Four capture channels share the same input pins. Each one can copy the counter into its own capture register on a rising edge, a falling edge or both, and can raise a flag when it does. Every pin passes through a two-flop synchronizer before edge detection, so a capture lands three clock edges after the pin changes. Software clears a flag by writing a one to its bit. The interrupt pin is high while any flag is set.

The register port is plain control: a write strobe with address and data, and a combinational read of the addressed word. The block has no data stream, so it has no valid/ready handshake and never applies back-pressure. A write always takes effect at the next clock edge.

Top module: `match_capture_timer`

## Requirements
- R1: Word addresses are fixed: 0 flags, 1 control, 2 counter, 3 prescale limit, 4 prescale counter, 5 match control, 6 to 9 match values 0 to 3, 10 capture control, 11 to 14 capture values 0 to 3, 15 external match, 28 count control. Addresses 16 to 27 read zero and ignore writes. Unused bits read zero.
- R2: After reset, every register reads zero, `irq` is low and `ext_out` is zero.
- R3: Control bit 0 enables counting. While control bit 1 is set, the counter and prescale counter are held at zero. While bit 0 is clear, the counter keeps its value.
- R4: In timer mode with prescale limit P, the prescale counter runs 0..P and the main counter advances once every P+1 enabled clock cycles.
- R5: Flag bit n (n = 0..3) is set when match channel n fires, that is on a counting step where counter equals match value n, provided match-control bit 3n is set. With bit 3n clear, no flag is raised.
- R6: With match-control bit 3n+1 set, a firing channel n sends the counter to zero instead of incrementing, so with value M and no prescale the counter repeats 0..M.
- R7: With match-control bit 3n+2 set, a firing channel n clears control bit 0 and the counter keeps its value.
- R8: The external match register holds the pin state of channel n in bit n. A firing channel applies the 2-bit action at bits 2n+5:2n+4: 0 none, 1 drive low, 2 drive high, 3 toggle. `ext_out` shows the state bits.
- R9: Capture-control bits 3n, 3n+1 and 3n+2 select capture on a rising edge, capture on a falling edge, and raising flag bit 4+n. A capture stores the counter value from two edges after the pin change has been sampled. An edge whose bit is clear is ignored.
- R10: Count-control bits 1:0 select the clock source: 0 timer, 1 rising, 2 falling, 3 both edges. Bits 3:2 choose the input pin. Edges on other pins do not count.
- R11: Writing one to a flag bit clears it, and writing zero leaves it. `irq` is high exactly when some flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| cap_in | input | 4 | Capture and count input pins |
| ext_out | output | 4 | External match output levels |
| irq | output | 1 | Interrupt, OR of all flags |

## Verification
The bench sweeps the prescale limit and the match value across small ranges and checks the counter after every edge. A wrong compare bound would stretch or shorten the period by one count. A reset-on-match that still incremented would run to M+1. The capture latency is checked to the exact edge, and a missing or extra synchronizer stage would store a counter value off by one. It also checks that a disabled edge polarity, an unselected count pin and a zero write to the flags change nothing. A design that treated these wrongly would show a moved capture value, an inflated count or a lost flag.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [1:0] {
    CM_TIMER = 2'd0,
    CM_RISE  = 2'd1,
    CM_FALL  = 2'd2,
    CM_BOTH  = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    EA_NONE   = 2'd0,
    EA_LOW    = 2'd1,
    EA_HIGH   = 2'd2,
    EA_TOGGLE = 2'd3
  } ext_act_e;

  // next level of an external match pin for a given action
  function automatic logic ext_apply(input ext_act_e act, input logic cur);
    case (act)
      EA_LOW:    return 1'b0;
      EA_HIGH:   return 1'b1;
      EA_TOGGLE: return ~cur;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/mct_sync_edge.sv
module mct_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
    assign fall[i] = ~s2 & s3;
  end

endmodule

// File: rtl/mct_tick_gen.sv
module mct_tick_gen
  import mct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_IN  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  cnt_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] presc,
  input  logic             pcnt_wr,
  input  logic [CNT_W-1:0] pcnt_wdata,
  input  logic [N_IN-1:0]  rise,
  input  logic [N_IN-1:0]  fall,
  output logic             tick,
  output logic [CNT_W-1:0] pcnt
);

  logic run, sel_rise, sel_fall, timer_tick, edge_tick;

  assign run = en & ~hold;

  always_comb begin
    sel_rise = 1'b0;
    sel_fall = 1'b0;
    if (int'(sel) < N_IN) begin
      sel_rise = rise[sel];
      sel_fall = fall[sel];
    end
  end

  assign timer_tick = run && (mode == CM_TIMER) && (pcnt >= presc);

  always_comb begin
    edge_tick = 1'b0;
    if (run) begin
      case (mode)
        CM_RISE: edge_tick = sel_rise;
        CM_FALL: edge_tick = sel_fall;
        CM_BOTH: edge_tick = sel_rise | sel_fall;
        default: edge_tick = 1'b0;
      endcase
    end
  end

  assign tick = timer_tick | edge_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (hold)
      pcnt <= '0;
    else if (pcnt_wr)
      pcnt <= pcnt_wdata;
    else if (run && mode == CM_TIMER)
      pcnt <= timer_tick ? '0 : pcnt + 1'b1;
  end

endmodule

// File: rtl/mct_match_bank.sv
module mct_match_bank
  import mct_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4
) (
  input  logic [CNT_W-1:0]              cnt,
  input  logic [N_MATCH-1:0][CNT_W-1:0] mval,
  input  logic [3*N_MATCH-1:0]          mctl,
  input  logic [2*N_MATCH-1:0]          ext_act,
  input  logic [N_MATCH-1:0]            ext_st,
  input  logic                          tick,
  output logic [N_MATCH-1:0]            hit,
  output logic [N_MATCH-1:0]            int_set,
  output logic [N_MATCH-1:0]            ext_upd,
  output logic [N_MATCH-1:0]            ext_val,
  output logic                          rst_req,
  output logic                          stop_req
);

  logic [N_MATCH-1:0] rst_v, stop_v;

  for (genvar ch = 0; ch < N_MATCH; ch++) begin : g_ch
    logic     fire;
    ext_act_e act;
    assign hit[ch]     = (cnt == mval[ch]);
    assign fire        = tick & hit[ch];
    assign act         = ext_act_e'(ext_act[2*ch +: 2]);
    assign int_set[ch] = fire & mctl[3*ch];
    assign rst_v[ch]   = fire & mctl[3*ch+1];
    assign stop_v[ch]  = fire & mctl[3*ch+2];
    assign ext_upd[ch] = fire && (act != EA_NONE);
    assign ext_val[ch] = ext_apply(act, ext_st[ch]);
  end

  assign rst_req  = |rst_v;
  assign stop_req = |stop_v;

endmodule

// File: rtl/mct_capture_bank.sv
module mct_capture_bank #(
  parameter int CNT_W = 32,
  parameter int N_CAP = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [3*N_CAP-1:0]          cctl,
  input  logic [N_CAP-1:0]            rise,
  input  logic [N_CAP-1:0]            fall,
  output logic [N_CAP-1:0][CNT_W-1:0] cap,
  output logic [N_CAP-1:0]            cap_set
);

  for (genvar ch = 0; ch < N_CAP; ch++) begin : g_ch
    logic             take;
    logic [CNT_W-1:0] hold_q;
    assign take = (rise[ch] & cctl[3*ch]) | (fall[ch] & cctl[3*ch+1]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hold_q <= '0;
      else if (take)
        hold_q <= cnt;
    end
    assign cap[ch]     = hold_q;
    assign cap_set[ch] = take & cctl[3*ch+2];
  end

endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer
  import mct_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4,
  parameter int ADDR_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [N_CAP-1:0]    cap_in,
  output logic [N_MATCH-1:0]  ext_out,
  output logic                irq
);

  localparam int FLAG_W   = N_MATCH + N_CAP;
  localparam int SEL_W    = (N_CAP > 1) ? $clog2(N_CAP) : 1;
  localparam int MCTL_W   = 3 * N_MATCH;
  localparam int CCTL_W   = 3 * N_CAP;
  localparam int A_FLAGS  = 0;
  localparam int A_CTRL   = 1;
  localparam int A_CNT    = 2;
  localparam int A_PRESC  = 3;
  localparam int A_PCNT   = 4;
  localparam int A_MCTL   = 5;
  localparam int A_MV0    = 6;
  localparam int A_CCTL   = A_MV0 + N_MATCH;
  localparam int A_CAP0   = A_CCTL + 1;
  localparam int A_EXT    = A_CAP0 + N_CAP;
  localparam int A_CNTCTL = A_EXT + 13;

  // register state
  logic                          ctrl_en, ctrl_hold;
  logic [CNT_W-1:0]              cnt, presc, pcnt;
  logic [MCTL_W-1:0]             mctl;
  logic [CCTL_W-1:0]             cctl;
  logic [N_MATCH-1:0][CNT_W-1:0] mval;
  logic [N_CAP-1:0][CNT_W-1:0]   cap;
  logic [N_MATCH-1:0]            ext_st;
  logic [2*N_MATCH-1:0]          ext_act;
  cnt_mode_e                     cmode;
  logic [SEL_W-1:0]              csel;
  logic [FLAG_W-1:0]             flags;

  // datapath nets
  logic                          tick, rst_req, stop_req;
  logic [N_CAP-1:0]              pin_rise, pin_fall, cap_set;
  logic [N_MATCH-1:0]            hit, match_int, ext_upd, ext_val;

  // write strobes
  logic wr_flags, wr_ctrl, wr_cnt, wr_presc, wr_pcnt, wr_mctl, wr_cctl, wr_ext, wr_cntctl;
  assign wr_flags  = wr_en && (addr == ADDR_W'(A_FLAGS));
  assign wr_ctrl   = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_cnt    = wr_en && (addr == ADDR_W'(A_CNT));
  assign wr_presc  = wr_en && (addr == ADDR_W'(A_PRESC));
  assign wr_pcnt   = wr_en && (addr == ADDR_W'(A_PCNT));
  assign wr_mctl   = wr_en && (addr == ADDR_W'(A_MCTL));
  assign wr_cctl   = wr_en && (addr == ADDR_W'(A_CCTL));
  assign wr_ext    = wr_en && (addr == ADDR_W'(A_EXT));
  assign wr_cntctl = wr_en && (addr == ADDR_W'(A_CNTCTL));

  mct_sync_edge #(.N(N_CAP)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_in),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  mct_tick_gen #(.CNT_W(CNT_W), .N_IN(N_CAP), .SEL_W(SEL_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_en),
    .hold      (ctrl_hold),
    .mode      (cmode),
    .sel       (csel),
    .presc     (presc),
    .pcnt_wr   (wr_pcnt),
    .pcnt_wdata(wdata[CNT_W-1:0]),
    .rise      (pin_rise),
    .fall      (pin_fall),
    .tick      (tick),
    .pcnt      (pcnt)
  );

  mct_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match (
    .cnt     (cnt),
    .mval    (mval),
    .mctl    (mctl),
    .ext_act (ext_act),
    .ext_st  (ext_st),
    .tick    (tick),
    .hit     (hit),
    .int_set (match_int),
    .ext_upd (ext_upd),
    .ext_val (ext_val),
    .rst_req (rst_req),
    .stop_req(stop_req)
  );

  mct_capture_bank #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt),
    .cctl   (cctl),
    .rise   (pin_rise),
    .fall   (pin_fall),
    .cap    (cap),
    .cap_set(cap_set)
  );

  // control: a stop-on-match beats a simultaneous software enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_hold <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en   <= wdata[0];
        ctrl_hold <= wdata[1];
      end
      if (stop_req)
        ctrl_en <= 1'b0;
    end
  end

  // main counter: hold, then software write, then counting step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (ctrl_hold)
      cnt <= '0;
    else if (wr_cnt)
      cnt <= wdata[CNT_W-1:0];
    else if (tick) begin
      if (rst_req)
        cnt <= '0;
      else if (!stop_req)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= '0;
      mctl    <= '0;
      cctl    <= '0;
      ext_act <= '0;
      cmode   <= CM_TIMER;
      csel    <= '0;
    end else begin
      if (wr_presc) presc <= wdata[CNT_W-1:0];
      if (wr_mctl)  mctl  <= wdata[MCTL_W-1:0];
      if (wr_cctl)  cctl  <= wdata[CCTL_W-1:0];
      if (wr_ext)   ext_act <= wdata[N_MATCH +: 2*N_MATCH];
      if (wr_cntctl) begin
        cmode <= cnt_mode_e'(wdata[1:0]);
        csel  <= wdata[2 +: SEL_W];
      end
    end
  end

  for (genvar n = 0; n < N_MATCH; n++) begin : g_mreg
    logic [CNT_W-1:0] mv_q;
    logic             st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mv_q <= '0;
      else if (wr_en && addr == ADDR_W'(A_MV0 + n))
        mv_q <= wdata[CNT_W-1:0];
    end
    // a match action wins over a software write of the pin state
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        st_q <= 1'b0;
      else if (ext_upd[n])
        st_q <= ext_val[n];
      else if (wr_ext)
        st_q <= wdata[n];
    end
    assign mval[n]   = mv_q;
    assign ext_st[n] = st_q;
  end

  // flags: new events win over a write-one clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags <= '0;
    else
      flags <= (flags & ~(wr_flags ? wdata[FLAG_W-1:0] : '0)) | {cap_set, match_int};
  end

  assign irq     = |flags;
  assign ext_out = ext_st;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_FLAGS))  rdata = DATA_W'(flags);
    if (addr == ADDR_W'(A_CTRL))   rdata = DATA_W'({ctrl_hold, ctrl_en});
    if (addr == ADDR_W'(A_CNT))    rdata = DATA_W'(cnt);
    if (addr == ADDR_W'(A_PRESC))  rdata = DATA_W'(presc);
    if (addr == ADDR_W'(A_PCNT))   rdata = DATA_W'(pcnt);
    if (addr == ADDR_W'(A_MCTL))   rdata = DATA_W'(mctl);
    if (addr == ADDR_W'(A_CCTL))   rdata = DATA_W'(cctl);
    if (addr == ADDR_W'(A_EXT))    rdata = DATA_W'({ext_act, ext_st});
    if (addr == ADDR_W'(A_CNTCTL)) rdata = DATA_W'({csel, cmode});
    for (int n = 0; n < N_MATCH; n++)
      if (addr == ADDR_W'(A_MV0 + n)) rdata = DATA_W'(mval[n]);
    for (int n = 0; n < N_CAP; n++)
      if (addr == ADDR_W'(A_CAP0 + n)) rdata = DATA_W'(cap[n]);
  end

endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       en,
  input logic                       hold,
  input logic                       cnt_wr,
  input logic [CNT_W-1:0]           cnt,
  input logic [CNT_W-1:0]           pcnt,
  input logic [N_MATCH-1:0]         hit,
  input logic [3*N_MATCH-1:0]       mctl,
  input logic [N_MATCH+N_CAP-1:0]   flags
);

  logic any_rst, any_stop;
  always_comb begin
    any_rst  = 1'b0;
    any_stop = 1'b0;
    for (int n = 0; n < N_MATCH; n++) begin
      any_rst  = any_rst  | (hit[n] & mctl[3*n+1]);
      any_stop = any_stop | (hit[n] & mctl[3*n+2]);
    end
  end

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0 && pcnt == '0));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold && !cnt_wr) |=> $stable(cnt));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !cnt_wr && !any_rst && !any_stop) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_match_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !cnt_wr && any_rst) |=> cnt == '0);

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && any_stop) |=> !en);

  assert_flag_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((flags[N_MATCH-1:0] & ~$past(flags[N_MATCH-1:0])) == '0));

endmodule

bind match_capture_timer mct_checker #(
  .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP)
) u_mct_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .en    (ctrl_en),
  .hold  (ctrl_hold),
  .cnt_wr(wr_cnt),
  .cnt   (cnt),
  .pcnt  (pcnt),
  .hit   (hit),
  .mctl  (mctl),
  .flags (flags)
);

// File: tb/test_match_capture_timer.sv
`timescale 1ns/1ps
module test_match_capture_timer;

  localparam int AW = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  cap_in;
  logic [3:0]  ext_out;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  match_capture_timer i_match_capture_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .ext_out(ext_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input int a, input logic [31:0] exp);
    addr = AW'(a);
    #0.1;
    chk(req, rdata, exp);
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; cap_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: everything zero after reset
    for (int a = 0; a <= 28; a++) rdchk("R2 reset register", a, 32'h0);
    chk("R2 reset irq", {31'b0, irq}, 32'h0);
    chk("R2 reset ext_out", {28'b0, ext_out}, 32'h0);

    // R1: map, masking, reserved words
    wr(3, 32'h1234_5678); rdchk("R1 prescale limit", 3, 32'h1234_5678);
    wr(7, 32'hA5A5_0001); rdchk("R1 match value 1", 7, 32'hA5A5_0001);
    wr(20, 32'hFFFF_FFFF); rdchk("R1 reserved word", 20, 32'h0);
    wr(28, 32'hFF); rdchk("R1 count control width", 28, 32'hF);
    wr(1, 32'hFF); rdchk("R1 control width", 1, 32'h3);
    wr(1, 32'h2); wr(28, 0); wr(3, 0); wr(7, 0);

    // R4: prescale sweep, counter and prescale counter after each edge
    for (int p = 0; p < 4; p++) begin
      wr(1, 32'h2); wr(3, p); wr(1, 32'h1);
      for (int k = 1; k <= 9; k++) begin
        edges(1);
        rdchk("R4 counter", 2, k / (p + 1));
        rdchk("R4 prescale counter", 4, k % (p + 1));
      end
    end

    // R5 R6 R11: reset-on-match with interrupt, match value sweep
    wr(1, 32'h2); wr(3, 0); wr(5, 32'h3);
    for (int m = 0; m < 4; m++) begin
      wr(1, 32'h2); wr(0, 32'hFF); wr(6, m); wr(1, 32'h1);
      for (int k = 1; k <= 2 * (m + 1); k++) begin
        edges(1);
        rdchk("R6 counter wraps", 2, k % (m + 1));
        rdchk("R5 match flag", 0, (k >= m + 1) ? 32'h1 : 32'h0);
        chk("R11 irq follows flags", {31'b0, irq}, (k >= m + 1) ? 32'h1 : 32'h0);
      end
      wr(1, 32'h2);
      wr(0, 32'h0); rdchk("R11 zero write keeps flag", 0, 32'h1);
      wr(0, 32'h1); rdchk("R11 one write clears flag", 0, 32'h0);
      chk("R11 irq low after clear", {31'b0, irq}, 32'h0);
    end

    // R7: stop on match channel 1 at 5, no interrupt bit
    wr(1, 32'h2); wr(6, 3); wr(5, 32'h20); wr(7, 5); wr(1, 32'h1);
    edges(20);
    rdchk("R7 counter held", 2, 32'd5);
    rdchk("R7 enable cleared", 1, 32'h0);
    rdchk("R5 no flag without enable bit", 0, 32'h0);

    // R8: external actions; ch1 low, ch2 toggle with reset, ch3 high
    wr(1, 32'h2); wr(5, 32'h80); wr(6, 0); wr(7, 0); wr(8, 2); wr(9, 1);
    wr(15, 32'hB42);
    rdchk("R8 external register", 15, 32'hB42);
    chk("R8 preset pin", {28'b0, ext_out}, 32'h2);
    wr(1, 32'h1);
    for (int k = 1; k <= 8; k++) begin
      edges(1);
      chk("R8 ext_out", {28'b0, ext_out},
          (((k / 3) % 2) << 2) | ((k >= 2) ? 32'h8 : 32'h0));
    end
    wr(1, 32'h2); wr(5, 0); wr(15, 0);

    // R9: rising capture with interrupt on channel 1, latency check
    wr(10, 32'h28); wr(0, 32'hFF); wr(1, 32'h1);
    cap_in[1] = 1'b1;
    edges(2);
    rdchk("R9 capture not yet", 12, 32'h0);
    edges(1);
    rdchk("R9 capture value", 12, 32'd2);
    rdchk("R9 capture flag", 0, 32'h20);
    cap_in[1] = 1'b0;
    edges(6);
    rdchk("R9 falling edge ignored", 12, 32'd2);

    // R9: both edges, no interrupt, frozen counter
    wr(1, 32'h0); wr(0, 32'hFF); wr(10, 32'h18); wr(2, 77);
    cap_in[1] = 1'b1; edges(5);
    rdchk("R9 both edges rise", 12, 32'd77);
    wr(2, 91);
    cap_in[1] = 1'b0; edges(5);
    rdchk("R9 both edges fall", 12, 32'd91);
    rdchk("R9 no flag without bit", 0, 32'h0);

    // R9: channel 3 falling only with interrupt
    wr(10, 32'hC00);
    cap_in[3] = 1'b1; edges(5);
    rdchk("R9 rise ignored ch3", 14, 32'h0);
    rdchk("R9 no flag on ignored edge", 0, 32'h0);
    cap_in[3] = 1'b0; edges(5);
    rdchk("R9 fall capture ch3", 14, 32'd91);
    rdchk("R9 flag ch3", 0, 32'h80);
    wr(10, 0);

    // R10: counter modes on pin 2, pin 0 pulses must not count
    for (int md = 1; md <= 3; md++) begin
      wr(1, 32'h2); wr(0, 32'hFF); wr(28, md | (2 << 2)); wr(1, 32'h1);
      for (int p = 0; p < 5; p++) begin
        cap_in[2] = 1'b1; edges(3);
        cap_in[2] = 1'b0; edges(3);
      end
      for (int p = 0; p < 3; p++) begin
        cap_in[0] = 1'b1; edges(3);
        cap_in[0] = 1'b0; edges(3);
      end
      edges(4);
      rdchk("R10 edge count", 2, (md == 3) ? 32'd10 : 32'd5);
    end

    // R3: hold with enable, release, disable
    wr(1, 32'h3); edges(3);
    rdchk("R3 hold counter", 2, 32'h0);
    rdchk("R3 hold prescale counter", 4, 32'h0);
    wr(28, 0); wr(1, 32'h1); edges(4);
    rdchk("R3 counting after release", 2, 32'd4);
    wr(1, 32'h0);
    addr = AW'(2); #0.1;
    begin
      logic [31:0] frozen;
      frozen = rdata;
      edges(5);
      rdchk("R3 disabled counter stable", 2, frozen);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule